// File: doc/BRIEF.md
# Watermark Pause Flow Controller

This block sits beside a full-duplex Ethernet MAC and handles both halves of PAUSE-based flow control. On the generating side it watches the fill level of the receive packet FIFO. When the level climbs past a programmable high mark, it asks the transmit MAC to send a PAUSE frame that halts the link partner. Once the level later sinks below a programmable low mark, it asks for a second PAUSE frame with zero quanta, which releases the partner. A rising edge on an external trigger input also asks for a halt frame. Requests reach the transmit MAC over a valid/ready handshake, and only one request is outstanding at a time.

On the honouring side, the block takes the quanta field decoded from each received PAUSE frame. It counts that many slot ticks, where one tick is 512 bit times, and holds a transmit-inhibit output high while the count is nonzero. Ticks are not counted while a frame is still being transmitted, so the pause time begins after the current frame has finished. A 2-bit mode input enables the two halves separately.

Top module: `pause_flow_ctrl`

## Requirements
- R1: After reset, `req_valid` and `tx_inhibit` are both low.
- R2: With generation enabled and the tracker idle, a FIFO level strictly above `high_mark` produces one halt request. `req_valid` rises after the second clock edge and carries `req_quanta` equal to `halt_quanta`.
- R3: After a halt, while the level has not yet dropped below `low_mark`, a level that stays high or crosses `high_mark` again produces no further halt request.
- R4: After a halt, a level strictly below `low_mark` produces one resume request with `req_quanta` equal to zero. A level below `low_mark` with no earlier halt produces nothing.
- R5: In `fc_mode`, bit 0 enables generating pause frames and bit 1 enables honouring received ones. 00 is no pause, 11 is symmetric, 10 is receive direction only and 01 is transmit direction only.
- R6: With generation enabled, each rising edge of `ext_pause` produces one halt request carrying `halt_quanta`. Holding the input high adds no further requests. With generation disabled, the input is ignored.
- R7: While `req_valid` is high and `req_ready` is low, `req_valid` and `req_quanta` stay stable. A second request that arises meanwhile waits, and it is presented right after the clock edge that completes the handshake.
- R8: When honouring is enabled, a received pause (`rx_pause_valid`) loads its quanta. `tx_inhibit` is high while the count is nonzero. Each `slot_tick` decrements the count, so `tx_inhibit` falls on the edge of the quanta-th tick.
- R9: A newly received pause reloads the count, and the load takes priority over a tick in the same cycle. A received quanta of zero clears `tx_inhibit` on the next edge.
- R10: While `tx_frame_active` is high, `slot_tick` does not decrement the count.
- R11: With honouring disabled, received pauses are ignored and any running count is cleared to zero.
- R12: With generation disabled, a halted tracker returns to idle without a resume request, pending requests are dropped, and no new request is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fc_mode | input | 2 | Bit 0 enables generation, bit 1 enables honouring |
| fifo_level | input | LEVEL_W | Current receive FIFO fill level |
| high_mark | input | LEVEL_W | Halt threshold (level strictly above it) |
| low_mark | input | LEVEL_W | Resume threshold (level strictly below it) |
| halt_quanta | input | QUANTA_W | Quanta sent in halt requests |
| ext_pause | input | 1 | External halt trigger, rising edge |
| req_valid | output | 1 | Pause request to the transmit MAC |
| req_quanta | output | QUANTA_W | Quanta for the requested frame |
| req_ready | input | 1 | Transmit MAC accepts the request |
| rx_pause_valid | input | 1 | A received PAUSE frame was decoded |
| rx_pause_quanta | input | QUANTA_W | Quanta of the received frame |
| slot_tick | input | 1 | One pulse per 512 bit times |
| tx_frame_active | input | 1 | The transmitter is in the middle of a frame |
| tx_inhibit | output | 1 | Do not start a new frame |

## Verification
The bench exercises the following corner cases:
- A dip below the low mark with no earlier halt. A design without the hysteresis state would send a stray resume.
- A level that sits above the high mark and then re-crosses it. A level-sensitive design would flood the MAC with halts.
- A halt held back by `req_ready` while a resume arises. This exposes a design that overwrites the held quanta or drops the second request.
- On the honouring side, a reload during a countdown, a zero-quanta frame, a load and a tick in the same cycle, ticks during an active frame, and disabling honouring in mid-count. Each of these would show up as `tx_inhibit` ending at the wrong tick or surviving when it should not.

// File: rtl/fc_pkg.sv
// Shared types and mode decoding for the pause flow controller.
package fc_pkg;

    // Hysteresis tracker state: idle (below high) or halted, awaiting low.
    typedef enum logic {
        WM_IDLE   = 1'b0,
        WM_HALTED = 1'b1
    } wm_state_t;

    // Bit positions inside the 2-bit flow-control mode.
    localparam int MODE_GEN_BIT    = 0;
    localparam int MODE_HONOUR_BIT = 1;

    // True when this port may generate pause frames.
    function automatic logic gen_enabled(input logic [1:0] mode);
        return mode[MODE_GEN_BIT];
    endfunction

    // True when this port obeys pause frames from the partner.
    function automatic logic honour_enabled(input logic [1:0] mode);
        return mode[MODE_HONOUR_BIT];
    endfunction

endpackage

// File: rtl/fc_watermark_fsm.sv
// Watermark hysteresis tracker.
// Emits a one-cycle halt event when the level rises strictly above the high
// mark from idle, and a one-cycle resume event when the level then falls
// strictly below the low mark. Assumes low_mark < high_mark. When generation
// is disabled it returns to idle silently.
module fc_watermark_fsm
    import fc_pkg::*;
#(
    parameter int LEVEL_W = 10
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               gen_en,
    input  logic [LEVEL_W-1:0] level,
    input  logic [LEVEL_W-1:0] high_mark,
    input  logic [LEVEL_W-1:0] low_mark,
    output logic               halt_evt,
    output logic               resume_evt
);

    wm_state_t state_q, state_d;
    logic      above_high;
    logic      below_low;

    // Threshold comparators.
    assign above_high = (level > high_mark);
    assign below_low  = (level < low_mark);

    // Next-state and event decode.
    always_comb begin
        state_d    = state_q;
        halt_evt   = 1'b0;
        resume_evt = 1'b0;
        unique case (state_q)
            WM_IDLE: begin
                if (gen_en && above_high) begin
                    state_d  = WM_HALTED;
                    halt_evt = 1'b1;
                end
            end
            WM_HALTED: begin
                if (!gen_en) begin
                    state_d = WM_IDLE;
                end else if (below_low) begin
                    state_d    = WM_IDLE;
                    resume_evt = 1'b1;
                end
            end
            default: state_d = WM_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= WM_IDLE;
        else        state_q <= state_d;
    end

endmodule

// File: rtl/fc_req_queue.sv
// Pause request issuer.
// Remembers at most one pending halt and one pending resume (a newer event
// cancels the opposite kind) and presents one request at a time on a
// valid/ready handshake. A halt takes halt_quanta, sampled when loaded; a
// resume carries zero. The presented request stays stable until accepted.
// Disabling generation drops pending requests and blocks new loads.
module fc_req_queue #(
    parameter int QUANTA_W = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                gen_en,
    input  logic                halt_evt,
    input  logic                resume_evt,
    input  logic                ext_rise,
    input  logic [QUANTA_W-1:0] halt_quanta,
    input  logic                req_ready,
    output logic                req_valid,
    output logic [QUANTA_W-1:0] req_quanta
);

    localparam logic [QUANTA_W-1:0] ZERO_QUANTA = '0;

    logic pend_halt_q, pend_resume_q;
    logic pend_halt_d, pend_resume_d;
    logic slot_free;
    logic load_halt, load_resume;
    logic want_halt;

    // The output slot is free when empty or being accepted this cycle.
    assign slot_free   = !req_valid || req_ready;
    assign load_halt   = gen_en && slot_free && pend_halt_q;
    assign load_resume = gen_en && slot_free && !pend_halt_q && pend_resume_q;
    assign want_halt   = halt_evt || ext_rise;

    // Pending flag update: clear on load, then apply new events.
    always_comb begin
        pend_halt_d   = pend_halt_q   && !load_halt;
        pend_resume_d = pend_resume_q && !load_resume;
        if (want_halt) begin
            pend_halt_d   = 1'b1;
            pend_resume_d = 1'b0;
        end else if (resume_evt) begin
            pend_resume_d = 1'b1;
            pend_halt_d   = 1'b0;
        end
        if (!gen_en) begin
            pend_halt_d   = 1'b0;
            pend_resume_d = 1'b0;
        end
    end

    // Pending flag registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_halt_q   <= 1'b0;
            pend_resume_q <= 1'b0;
        end else begin
            pend_halt_q   <= pend_halt_d;
            pend_resume_q <= pend_resume_d;
        end
    end

    // Output request register with handshake.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_valid  <= 1'b0;
            req_quanta <= ZERO_QUANTA;
        end else if (load_halt) begin
            req_valid  <= 1'b1;
            req_quanta <= halt_quanta;
        end else if (load_resume) begin
            req_valid  <= 1'b1;
            req_quanta <= ZERO_QUANTA;
        end else if (req_valid && req_ready) begin
            req_valid  <= 1'b0;
        end
    end

endmodule

// File: rtl/fc_quanta_timer.sv
// Received-pause timer.
// Loads the quanta of each received pause frame while honouring is enabled
// and counts it down by one per slot tick. Ticks are not counted while a
// frame is in progress. Inhibit is high while the count is nonzero. A load
// beats a tick in the same cycle. Disabling honouring clears the count.
module fc_quanta_timer #(
    parameter int QUANTA_W = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                honour_en,
    input  logic                rx_valid,
    input  logic [QUANTA_W-1:0] rx_quanta,
    input  logic                slot_tick,
    input  logic                frame_active,
    output logic                inhibit
);

    localparam logic [QUANTA_W-1:0] ONE = QUANTA_W'(1);

    logic [QUANTA_W-1:0] count_q;
    logic                count_nz;

    assign count_nz = (count_q != '0);

    // Count register: clear, load, or decrement.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_q <= '0;
        end else if (!honour_en) begin
            count_q <= '0;
        end else if (rx_valid) begin
            count_q <= rx_quanta;
        end else if (slot_tick && !frame_active && count_nz) begin
            count_q <= count_q - ONE;
        end
    end

    // Inhibit follows the nonzero count.
    assign inhibit = count_nz;

endmodule

// File: rtl/pause_flow_ctrl.sv
// Top of the pause flow controller.
// Decodes the mode, detects the rising edge of the external trigger, and
// joins the watermark tracker, the request issuer and the received-pause
// timer. All inputs are assumed synchronous to clk.
module pause_flow_ctrl
    import fc_pkg::*;
#(
    parameter int LEVEL_W  = 10,
    parameter int QUANTA_W = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [1:0]          fc_mode,
    input  logic [LEVEL_W-1:0]  fifo_level,
    input  logic [LEVEL_W-1:0]  high_mark,
    input  logic [LEVEL_W-1:0]  low_mark,
    input  logic [QUANTA_W-1:0] halt_quanta,
    input  logic                ext_pause,
    output logic                req_valid,
    output logic [QUANTA_W-1:0] req_quanta,
    input  logic                req_ready,
    input  logic                rx_pause_valid,
    input  logic [QUANTA_W-1:0] rx_pause_quanta,
    input  logic                slot_tick,
    input  logic                tx_frame_active,
    output logic                tx_inhibit
);

    logic gen_en, honour_en;
    logic halt_evt, resume_evt;
    logic ext_q, ext_rise;

    assign gen_en    = gen_enabled(fc_mode);
    assign honour_en = honour_enabled(fc_mode);

    // External trigger edge detector register.
    always_ff @(posedge clk) begin
        if (!rst_n) ext_q <= 1'b0;
        else        ext_q <= ext_pause;
    end
    assign ext_rise = gen_en && ext_pause && !ext_q;

    fc_watermark_fsm #(.LEVEL_W(LEVEL_W)) u_wm (
        .clk        (clk),
        .rst_n      (rst_n),
        .gen_en     (gen_en),
        .level      (fifo_level),
        .high_mark  (high_mark),
        .low_mark   (low_mark),
        .halt_evt   (halt_evt),
        .resume_evt (resume_evt)
    );

    fc_req_queue #(.QUANTA_W(QUANTA_W)) u_req (
        .clk         (clk),
        .rst_n       (rst_n),
        .gen_en      (gen_en),
        .halt_evt    (halt_evt),
        .resume_evt  (resume_evt),
        .ext_rise    (ext_rise),
        .halt_quanta (halt_quanta),
        .req_ready   (req_ready),
        .req_valid   (req_valid),
        .req_quanta  (req_quanta)
    );

    fc_quanta_timer #(.QUANTA_W(QUANTA_W)) u_tmr (
        .clk          (clk),
        .rst_n        (rst_n),
        .honour_en    (honour_en),
        .rx_valid     (rx_pause_valid),
        .rx_quanta    (rx_pause_quanta),
        .slot_tick    (slot_tick),
        .frame_active (tx_frame_active),
        .inhibit      (tx_inhibit)
    );

endmodule

// File: rtl/pause_flow_ctrl_checker.sv
// Port-level property checker for pause_flow_ctrl, attached by bind.
module pause_flow_ctrl_checker #(
    parameter int QUANTA_W = 16
) (
    input logic                clk,
    input logic                rst_n,
    input logic [1:0]          fc_mode,
    input logic                req_valid,
    input logic [QUANTA_W-1:0] req_quanta,
    input logic                req_ready,
    input logic                rx_pause_valid,
    input logic [QUANTA_W-1:0] rx_pause_quanta,
    input logic                tx_frame_active,
    input logic                tx_inhibit
);

    // A stalled request holds steady.
    assert_req_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_ready) |=> (req_valid && $stable(req_quanta)));

    // Generation disabled: no new request appears.
    assert_no_new_req_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (!fc_mode[0] && !req_valid) |=> !req_valid);

    // A zero-quanta frame ends the inhibit.
    assert_zero_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_pause_valid && rx_pause_quanta == '0) |=> !tx_inhibit);

    // A nonzero frame being honoured raises the inhibit.
    assert_load_inhibits_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_pause_valid && fc_mode[1] && rx_pause_quanta != '0) |=> tx_inhibit);

    // Honouring off: the inhibit is dropped.
    assert_honour_off_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !fc_mode[1] |=> !tx_inhibit);

    // Frame in progress freezes the count.
    assert_frame_freeze_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_frame_active && !rx_pause_valid && fc_mode[1]) |=> $stable(tx_inhibit));

endmodule

bind pause_flow_ctrl pause_flow_ctrl_checker #(.QUANTA_W(QUANTA_W)) u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .fc_mode         (fc_mode),
    .req_valid       (req_valid),
    .req_quanta      (req_quanta),
    .req_ready       (req_ready),
    .rx_pause_valid  (rx_pause_valid),
    .rx_pause_quanta (rx_pause_quanta),
    .tx_frame_active (tx_frame_active),
    .tx_inhibit      (tx_inhibit)
);

// File: tb/pause_flow_ctrl_test.sv
module pause_flow_ctrl_test;

    localparam int LW = 10;
    localparam int QW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [1:0]    fc_mode = 2'b00;
    logic [LW-1:0] fifo_level = '0;
    logic [LW-1:0] high_mark = 10'd100;
    logic [LW-1:0] low_mark = 10'd20;
    logic [QW-1:0] halt_quanta = 16'h1234;
    logic          ext_pause = 1'b0;
    logic          req_valid;
    logic [QW-1:0] req_quanta;
    logic          req_ready = 1'b0;
    logic          rx_pause_valid = 1'b0;
    logic [QW-1:0] rx_pause_quanta = '0;
    logic          slot_tick = 1'b0;
    logic          tx_frame_active = 1'b0;
    logic          tx_inhibit;

    int total = 0;
    int bad = 0;
    int cycles = 0;
    bit done = 0;

    always #10 clk = ~clk;

    pause_flow_ctrl #(.LEVEL_W(LW), .QUANTA_W(QW)) uut (
        .clk(clk), .rst_n(rst_n), .fc_mode(fc_mode), .fifo_level(fifo_level),
        .high_mark(high_mark), .low_mark(low_mark), .halt_quanta(halt_quanta),
        .ext_pause(ext_pause), .req_valid(req_valid), .req_quanta(req_quanta),
        .req_ready(req_ready), .rx_pause_valid(rx_pause_valid),
        .rx_pause_quanta(rx_pause_quanta), .slot_tick(slot_tick),
        .tx_frame_active(tx_frame_active), .tx_inhibit(tx_inhibit)
    );

    // Timer vectors: [15] rx valid, [14] tick, [13] frame active,
    // [12] expected inhibit after the edge, [11:0] received quanta.
    localparam int NV = 18;
    localparam logic [15:0] TV [NV] = '{
        16'h9003, 16'h5000, 16'h7000, 16'h5000, 16'h4000, 16'h4000,
        16'h9002, 16'h5000, 16'h9004, 16'h5000, 16'h5000, 16'h8000,
        16'h0000, 16'h9001, 16'h7000, 16'h4000, 16'hD001, 16'h4000
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    // Expect a request two edges after the trigger, with given quanta.
    task automatic expect_req(input string tag, input logic [QW-1:0] q);
        step();
        chk({tag, " not yet valid"}, 32'(req_valid), 32'd0);
        step();
        chk({tag, " valid"}, 32'(req_valid), 32'd1);
        chk({tag, " quanta"}, 32'(req_quanta), 32'(q));
    endtask

    task automatic accept();
        req_ready = 1'b1;
        step();
        req_ready = 1'b0;
    endtask

    task automatic expect_none(input string tag, input int n);
        int seen = 0;
        for (int i = 0; i < n; i++) begin
            step();
            if (req_valid) seen++;
        end
        chk(tag, 32'(seen), 32'd0);
    endtask

    // Watchdog.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000 && !done) begin
            done = 1;
            total++;
            bad++;
            $display("FAIL watchdog actual=%0d expected=<100000", cycles);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        step(); step();
        // R1 reset state
        chk("R1 req_valid", 32'(req_valid), 32'd0);
        chk("R1 tx_inhibit", 32'(tx_inhibit), 32'd0);
        rst_n = 1'b1;

        // Timer vector walk, symmetric mode, level between marks (R8 R9 R10)
        fc_mode = 2'b11;
        fifo_level = 10'd50;
        for (int i = 0; i < NV; i++) begin
            rx_pause_valid  = TV[i][15];
            slot_tick       = TV[i][14];
            tx_frame_active = TV[i][13];
            rx_pause_quanta = {4'd0, TV[i][11:0]};
            step();
            chk($sformatf("R8/R9/R10 vector %0d inhibit", i), 32'(tx_inhibit), 32'(TV[i][12]));
        end
        rx_pause_valid = 1'b0; slot_tick = 1'b0; tx_frame_active = 1'b0;

        // R11: honouring off clears the count, re-enabling leaves it cleared
        rx_pause_valid = 1'b1; rx_pause_quanta = 16'd5;
        step();
        rx_pause_valid = 1'b0;
        chk("R11 loaded", 32'(tx_inhibit), 32'd1);
        fc_mode = 2'b01;
        step();
        chk("R11 cleared", 32'(tx_inhibit), 32'd0);
        fc_mode = 2'b11;
        step();
        chk("R11 stays cleared", 32'(tx_inhibit), 32'd0);
        // R11/R5: transmit-only mode ignores received pauses
        fc_mode = 2'b01;
        rx_pause_valid = 1'b1; rx_pause_quanta = 16'd7;
        step();
        rx_pause_valid = 1'b0;
        chk("R11 ignored in mode 01", 32'(tx_inhibit), 32'd0);

        // R4: dip below low without a prior halt does nothing
        fc_mode = 2'b11;
        fifo_level = 10'd5;
        expect_none("R4 no resume without halt", 5);

        // R2: crossing high requests a halt; R7: held while not ready
        fifo_level = 10'd150;
        expect_req("R2 halt", 16'h1234);
        halt_quanta = 16'h0999;
        step(); step(); step();
        chk("R7 held valid", 32'(req_valid), 32'd1);
        chk("R7 held quanta", 32'(req_quanta), 32'h1234);
        accept();
        chk("R7 released", 32'(req_valid), 32'd0);

        // R3: staying high or re-crossing gives no new halt
        fifo_level = 10'd120;
        expect_none("R3 no duplicate", 3);
        fifo_level = 10'd160;
        expect_none("R3 re-cross", 3);
        fifo_level = 10'd50;
        expect_none("R4 between marks", 3);

        // R4: below low after halt gives resume with zero quanta
        fifo_level = 10'd10;
        expect_req("R4 resume", 16'h0000);
        accept();
        chk("R4 single resume", 32'(req_valid), 32'd0);

        // R5: receive-only mode generates nothing
        fc_mode = 2'b10;
        fifo_level = 10'd150;
        expect_none("R5 mode 10 no halt", 4);
        ext_pause = 1'b1;
        expect_none("R6 ext ignored when gen off", 3);
        ext_pause = 1'b0;
        fifo_level = 10'd50;
        step();

        // R6: external edge gives one halt in transmit-only mode
        fc_mode = 2'b01;
        halt_quanta = 16'h0042;
        ext_pause = 1'b1;
        expect_req("R6 ext halt", 16'h0042);
        accept();
        expect_none("R6 held level no repeat", 4);
        ext_pause = 1'b0;
        step();

        // R7: resume arising while halt outstanding waits its turn
        fifo_level = 10'd150;
        expect_req("R7 halt first", 16'h0042);
        fifo_level = 10'd10;
        step(); step(); step();
        chk("R7 halt still presented", 32'(req_quanta), 32'h0042);
        accept();
        chk("R7 resume follows valid", 32'(req_valid), 32'd1);
        chk("R7 resume follows quanta", 32'(req_quanta), 32'h0000);
        accept();
        chk("R7 queue empty", 32'(req_valid), 32'd0);

        // R12: disable generation while halted; no resume, back to idle
        fifo_level = 10'd150;
        expect_req("R12 halt", 16'h0042);
        accept();
        fc_mode = 2'b00;
        fifo_level = 10'd10;
        expect_none("R12 no resume when off", 3);
        fc_mode = 2'b01;
        expect_none("R12 idle after re-enable", 3);
        fifo_level = 10'd150;
        expect_req("R12 fresh halt", 16'h0042);
        accept();

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule